// File: doc/BRIEF.md
# Register-Bus Core Address Selector

This block sits between a host register bus and a set of peripheral cores. The bus carries 32-bit data and an address of configurable width. The low 8 address bits pick a register inside a 256-register block. Each core owns a window of one or more consecutive blocks. The selector decodes which window the address falls in and asserts chip-select and write-enable for that core only. It passes the address relative to the window base to the core, and it steers that core's read data and error flag back to the host.

Some cores answer from block memory, so their read data arrives one clock after the address. When at least one such core is present, the selector delays the data of every combinational core by one register. All cores then answer with the same one-cycle latency. When no core uses block memory, the whole return path is combinational. The error flag is reported only for cores that are configured to have one. An access that hits no window answers a read with zero data and a raised error.

Top module: `core_addr_sel`

## Requirements
- R1: Data is 32 bits wide and the address width is the parameter `ADDR_W`; both 24 and 17 must build. Address bits [7:0] index a register inside a 256-register block, and bits [ADDR_W-1:8] form the block number.
- R2: Windows are allocated in list order, starting at block 0. Each window starts at the next free block rounded up to a multiple of its block count rounded up to a power of two. With the default block counts {1, 4, 16, 2}, core 0 owns block 0, core 1 owns blocks 4–7, core 2 owns blocks 16–31 and core 3 owns blocks 32–33. Blocks 1–3, 8–15 and 34 and above are unmapped.
- R3: During an access that hits a window, `core_addr` equals the bus address minus 256 times that window's base block.
- R4: `core_cs` bit i is set only while `bus_cs` is high and the address lies in window i, and `core_we` bit i additionally requires `bus_we`; at most one bit of each is ever set.
- R5: A read (`bus_cs`=1, `bus_we`=0) to an unmapped address returns `bus_rdata` = 32'h0000_0000 with `bus_err` = 1 in its response cycle. A write to an unmapped address asserts no `core_cs`, no `core_we` and no error.
- R6: When any bit of `CORE_BRAM` is set, the response to an access (data and error) appears in the cycle after the address is presented, for every core. Memory-backed cores pass their data through unchanged, and combinational cores pass through one register.
- R7: When `CORE_BRAM` is all zero, the response appears combinationally in the same cycle as the address.
- R8: `bus_err` reflects `core_err` bit i only for cores whose `CORE_ERR` bit is set. A core without that option never raises `bus_err`, and its read data is still returned.
- R9: When `bus_cs` is low, no core is selected and the response is `bus_rdata` = 0, `bus_err` = 0.
- R10: Reset is synchronous and active-low. It clears the registered select, the registered miss flag and the delay registers, so the response in the cycle after a reset edge is 0 with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs | input | 1 | Host access strobe |
| bus_we | input | 1 | Host write (1) or read (0) |
| bus_addr | input | ADDR_W | Host register address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Read data returned to host |
| bus_err | output | 1 | Error for the access being answered |
| core_cs | output | NUM_CORES | Per-core select |
| core_we | output | NUM_CORES | Per-core write enable |
| core_addr | output | ADDR_W | Address relative to the selected window |
| core_wdata | output | 32 | Write data forwarded to cores |
| core_rdata | input | 32*NUM_CORES | Read data of all cores, core i at [32i+31:32i] |
| core_err | input | NUM_CORES | Error flag from each core |

## Verification
In the delayed build, a new access is decoded in the same cycle as the response to the previous one, which uses the registered select. The bench provokes this overlap with a read of core 0 followed directly by a write to core 2. In the second cycle it checks that `bus_rdata` still holds core 0's data while `core_cs` and `core_we` already point at core 2. A reset edge with a read pending provokes a similar overlap between the clearing of the delay registers and a live access. There the response must come back zero.

// File: rtl/core_sel_pkg.sv
package core_sel_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned BLK_BITS = 8;

  // smallest power of two not below n (n >= 1)
  function automatic int unsigned pow2_ceil(input int unsigned n);
    int unsigned p;
    p = 1;
    for (int k = 0; k < 31; k++) begin
      if (p < n) p = p * 2;
    end
    return p;
  endfunction

  // round v up to a multiple of a
  function automatic int unsigned align_up(input int unsigned v, input int unsigned a);
    return ((v + a - 1) / a) * a;
  endfunction
endpackage

// File: rtl/csel_window.sv
module csel_window #(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned BASE_BLK = 0,
  parameter int unsigned NUM_BLK  = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] offset
);
  import core_sel_pkg::*;

  localparam int unsigned BLK_W = ADDR_W - BLK_BITS;

  logic [BLK_W-1:0] blk;
  logic [31:0]      blk_ext;

  assign blk     = addr[ADDR_W-1:BLK_BITS];
  assign blk_ext = 32'(blk);
  assign hit     = (blk_ext >= BASE_BLK) && (blk_ext < BASE_BLK + NUM_BLK);
  assign offset  = addr - ADDR_W'(BASE_BLK * 256);
endmodule

// File: rtl/csel_lat_stage.sv
module csel_lat_stage #(
  parameter int unsigned WIDTH = 32,
  parameter bit          DELAY = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  generate
    if (DELAY) begin : g_reg
      logic [WIDTH-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= din;
      end
      assign dout = q;
    end else begin : g_thru
      assign dout = din;
    end
  endgenerate

  AST_STAGE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (dout == (DELAY ? $past(din) : din)))
    else $error("stage latency mismatch"); // R6
endmodule

// File: rtl/csel_rdmux.sv
module csel_rdmux #(
  parameter int unsigned NUM_CORES = 4
) (
  input  logic [NUM_CORES-1:0]    sel,
  input  logic                    miss,
  input  logic [32*NUM_CORES-1:0] rdata_in,
  input  logic [NUM_CORES-1:0]    err_in,
  output logic [31:0]             rdata_out,
  output logic                    err_out
);
  always_comb begin
    rdata_out = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      rdata_out = rdata_out | (rdata_in[32*i +: 32] & {32{sel[i]}});
    end
  end

  assign err_out = miss | (|(sel & err_in));
endmodule

// File: rtl/core_addr_sel.sv
module core_addr_sel #(
  parameter int unsigned ADDR_W                   = 24,
  parameter int unsigned NUM_CORES                = 4,
  parameter int unsigned CORE_BLOCKS [NUM_CORES]  = '{1, 4, 16, 2},
  parameter bit [NUM_CORES-1:0] CORE_BRAM         = 4'b0010,
  parameter bit [NUM_CORES-1:0] CORE_ERR          = 4'b0101
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_cs,
  input  logic                    bus_we,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic                    bus_err,
  output logic [NUM_CORES-1:0]    core_cs,
  output logic [NUM_CORES-1:0]    core_we,
  output logic [ADDR_W-1:0]       core_addr,
  output logic [31:0]             core_wdata,
  input  logic [32*NUM_CORES-1:0] core_rdata,
  input  logic [NUM_CORES-1:0]    core_err
);
  import core_sel_pkg::*;

  localparam bit ANY_BRAM = |CORE_BRAM;

  // base block of window idx: list order, aligned to pow2 of its size
  function automatic int unsigned base_of(input int unsigned idx);
    int unsigned nxt, b, res;
    nxt = 0;
    res = 0;
    for (int unsigned k = 0; k < NUM_CORES; k++) begin
      b = align_up(nxt, pow2_ceil(CORE_BLOCKS[k]));
      if (k == idx) res = b;
      nxt = b + CORE_BLOCKS[k];
    end
    return res;
  endfunction

  logic [NUM_CORES-1:0]    win_hit;
  logic [ADDR_W-1:0]       win_off [NUM_CORES];
  logic [NUM_CORES-1:0]    sel_now;
  logic                    miss_rd_now;
  logic [NUM_CORES-1:0]    sel_resp;
  logic                    miss_resp;
  logic [32*NUM_CORES-1:0] rdata_al;
  logic [NUM_CORES-1:0]    err_al;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CORES; gi++) begin : g_core
      localparam int unsigned BASE = base_of(gi);
      logic err_opt;

      csel_window #(.ADDR_W(ADDR_W), .BASE_BLK(BASE), .NUM_BLK(CORE_BLOCKS[gi])) u_win (
        .addr(bus_addr), .hit(win_hit[gi]), .offset(win_off[gi]));

      // cores without the error option contribute nothing
      assign err_opt = core_err[gi] & CORE_ERR[gi];

      csel_lat_stage #(.WIDTH(33), .DELAY(ANY_BRAM && !CORE_BRAM[gi])) u_align (
        .clk(clk), .rst_n(rst_n),
        .din({err_opt, core_rdata[32*gi +: 32]}),
        .dout({err_al[gi], rdata_al[32*gi +: 32]}));

      if (!CORE_ERR[gi]) begin : g_noerr
        AST_NO_ERR_OPT: assert property (@(posedge clk) disable iff (!rst_n)
          (sel_resp[gi] && !miss_resp) |-> !bus_err)
          else $error("error from core without error option"); // R8
      end
    end
  endgenerate

  assign sel_now     = win_hit & {NUM_CORES{bus_cs}};
  assign miss_rd_now = bus_cs & ~bus_we & ~(|win_hit);

  assign core_cs    = sel_now;
  assign core_we    = sel_now & {NUM_CORES{bus_we}};
  assign core_wdata = bus_wdata;

  always_comb begin
    core_addr = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      core_addr = core_addr | (win_off[i] & {ADDR_W{win_hit[i]}});
    end
  end

  // registered select and miss when any core reads from block memory
  csel_lat_stage #(.WIDTH(NUM_CORES + 1), .DELAY(ANY_BRAM)) u_sel_stage (
    .clk(clk), .rst_n(rst_n),
    .din({miss_rd_now, sel_now}),
    .dout({miss_resp, sel_resp}));

  csel_rdmux #(.NUM_CORES(NUM_CORES)) u_mux (
    .sel(sel_resp), .miss(miss_resp),
    .rdata_in(rdata_al), .err_in(err_al),
    .rdata_out(bus_rdata), .err_out(bus_err));

  AST_ONE_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(core_cs)) else $error("several cores selected"); // R4
  AST_WE_ONLY_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (core_we & ~core_cs) == '0) else $error("write enable without select"); // R4
  AST_MISS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    miss_resp |-> (bus_rdata == 32'h0 && bus_err)) else $error("miss response wrong"); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cs |-> (core_cs == '0 && core_we == '0)) else $error("select while idle"); // R9
endmodule

// File: tb/test_core_addr_sel.sv
`timescale 1ns/1ps
module test_core_addr_sel;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        bus_cs, bus_we;
  logic [23:0] bus_addr;
  logic [31:0] bus_wdata;

  // delayed build (core 1 memory-backed), 24-bit address
  logic [31:0]  rdata1;
  logic         err1;
  logic [3:0]   cs1, we1;
  logic [23:0]  caddr1;
  logic [31:0]  cwdata1;
  logic [127:0] crdata1;
  logic [3:0]   cerr1;
  logic [31:0]  bram_q;

  // combinational build, 17-bit address
  logic [31:0]  rdata2;
  logic         err2;
  logic [3:0]   cs2, we2;
  logic [16:0]  caddr2;
  logic [31:0]  cwdata2;
  logic [127:0] crdata2;
  logic [3:0]   cerr2;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  function automatic logic [31:0] fcore(input int i, input logic [23:0] off);
    return {4'(i), 4'hC, off};
  endfunction

  function automatic logic ecore(input logic [23:0] off);
    return off[7:0] == 8'hEE;
  endfunction

  always_ff @(posedge clk) bram_q <= fcore(1, caddr1);

  assign crdata1 = {fcore(3, caddr1), fcore(2, caddr1), bram_q, fcore(0, caddr1)};
  assign cerr1   = {ecore(caddr1), ecore(caddr1), 1'b0, ecore(caddr1)};
  assign crdata2 = {fcore(3, 24'(caddr2)), fcore(2, 24'(caddr2)),
                    fcore(1, 24'(caddr2)), fcore(0, 24'(caddr2))};
  assign cerr2   = {ecore(24'(caddr2)), ecore(24'(caddr2)), 1'b0, ecore(24'(caddr2))};

  core_addr_sel #(.ADDR_W(24), .NUM_CORES(4), .CORE_BLOCKS('{1, 4, 16, 2}),
                  .CORE_BRAM(4'b0010), .CORE_ERR(4'b0101)) i_core_addr_sel (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata1), .bus_err(err1), .core_cs(cs1), .core_we(we1),
    .core_addr(caddr1), .core_wdata(cwdata1), .core_rdata(crdata1), .core_err(cerr1));

  core_addr_sel #(.ADDR_W(17), .NUM_CORES(4), .CORE_BLOCKS('{1, 4, 16, 2}),
                  .CORE_BRAM(4'b0000), .CORE_ERR(4'b0101)) i_core_addr_sel_comb (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_addr(bus_addr[16:0]), .bus_wdata(bus_wdata),
    .bus_rdata(rdata2), .bus_err(err2), .core_cs(cs2), .core_we(we2),
    .core_addr(caddr2), .core_wdata(cwdata2), .core_rdata(crdata2), .core_err(cerr2));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R2 map written from the requirement: bases 0, 4, 16, 32
  task automatic map(input logic [23:0] a, output int idx, output logic [23:0] off);
    int b;
    b = int'(a >> 8);
    idx = -1;
    off = '0;
    if (b == 0)                 begin idx = 0; off = a;             end
    else if (b >= 4 && b < 8)   begin idx = 1; off = a - 24'h400;   end
    else if (b >= 16 && b < 32) begin idx = 2; off = a - 24'h1000;  end
    else if (b >= 32 && b < 34) begin idx = 3; off = a - 24'h2000;  end
  endtask

  task automatic do_read(input logic [23:0] a, input string tag);
    int idx;
    logic [23:0] off;
    logic [31:0] ed;
    logic ee;
    map(a, idx, off);
    ed = (idx >= 0) ? fcore(idx, off) : 32'h0;
    ee = (idx < 0) ? 1'b1 : ((idx == 0 || idx == 2) && ecore(off));
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    chk({tag, " R2/R4 cs"}, 32'(cs1), (idx >= 0) ? 32'(1 << idx) : 32'h0);
    chk({tag, " R4 we"}, 32'(we1), 32'h0);
    if (idx >= 0) chk({tag, " R3 offset"}, 32'(caddr1), 32'(off));
    chk({tag, " R7 rdata"}, rdata2, ed);
    chk({tag, " R7 err"}, 32'(err2), 32'(ee));
    @(posedge clk); #1;
    chk({tag, " R6 rdata"}, rdata1, ed);
    chk({tag, " R6 err"}, 32'(err1), 32'(ee));
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk("R10 rdata after reset", rdata1, 32'h0);
    chk("R10 err after reset", 32'(err1), 32'h0);
    chk("R9 cs idle", 32'(cs1), 32'h0);
  endtask

  task automatic t_hits;
    do_read(24'h0000FF, "core0 top");
    do_read(24'h000400, "core1 first");
    do_read(24'h0007FF, "core1 last");
    do_read(24'h001000, "core2 first");
    do_read(24'h001FFF, "core2 last");
    do_read(24'h002000, "core3 first");
    do_read(24'h0021FF, "core3 last");
  endtask

  task automatic t_misses;
    do_read(24'h000100, "R5 hole 1");
    do_read(24'h000800, "R5 hole 8");
    do_read(24'h000FFF, "R5 hole 15");
    do_read(24'h002200, "R5 past end");
    do_read(24'hFF0000, "R5 high R1");
  endtask

  task automatic t_errors;
    do_read(24'h0000EE, "R8 core0 err on");
    do_read(24'h0020EE, "R8 core3 err off");
    do_read(24'h0015EE, "R8 core2 err on");
  endtask

  task automatic t_writes;
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = 24'h001234; bus_wdata = 32'hCAFE_0001;
    #1;
    chk("R4 write cs", 32'(cs1), 32'h4);
    chk("R4 write we", 32'(we1), 32'h4);
    chk("R1 wdata", cwdata1, 32'hCAFE_0001);
    @(negedge clk);
    bus_addr = 24'h000100;
    #1;
    chk("R5 miss write cs", 32'(cs1), 32'h0);
    chk("R5 miss write we", 32'(we1), 32'h0);
    chk("R5 miss write err comb", 32'(err2), 32'h0);
    @(posedge clk); #1;
    chk("R5 miss write err", 32'(err1), 32'h0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    bus_cs = 1'b0; bus_we = 1'b0; bus_addr = 24'h001000;
    #1;
    chk("R9 idle cs", 32'(cs1), 32'h0);
    chk("R9 idle rdata comb", rdata2, 32'h0);
    @(posedge clk); #1;
    chk("R9 idle rdata", rdata1, 32'h0);
    chk("R9 idle err", 32'(err1), 32'h0);
  endtask

  task automatic t_overlap;
    do_read(24'h000012, "overlap read");
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = 24'h001034;
    #1;
    chk("R6 overlap old data", rdata1, fcore(0, 24'h12));
    chk("R4 overlap new cs", 32'(cs1), 32'h4);
    chk("R4 overlap new we", 32'(we1), 32'h4);
  endtask

  task automatic t_reset_mid;
    do_read(24'h001500, "pre reset");
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b0; bus_addr = 24'h000033; rst_n = 1'b0;
    @(posedge clk); #1;
    chk("R10 rdata reset edge", rdata1, 32'h0);
    chk("R10 err reset edge", 32'(err1), 32'h0);
    @(negedge clk);
    rst_n = 1'b1; bus_cs = 1'b0;
    @(posedge clk); #1;
  endtask

  initial begin
    rst_n = 1'b0; bus_cs = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_hits();
    t_misses();
    t_errors();
    t_writes();
    t_idle();
    t_overlap();
    t_reset_mid();
    do_read(24'h000500, "after reset");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule